// File: doc/BRIEF.md
# Event Monitor Capture Buffer

This block watches a stream of 32-bit event words and keeps a copy of the leading events so that software can look at them. A word carries a start-of-event flag, an end-of-event flag, or both. Each stored event goes to a page of its own and starts at offset zero of that page. When the event's last word arrives, the number of words in the event is recorded against that page.

Software reads through a window. It picks an offset inside the current read page and gets the word one clock later. It can also see how many complete events are still unread, the size of the event under the read page, and two flags that show whether the capture store is exhausted and whether anything is waiting. In run mode a page command with bit 0 clear releases the event under the read page and moves to the next page. With run mode off, the same command loads the page number directly, so any page can be inspected. After the capture limit, events are no longer stored, but the event and word statistics keep counting. A separate counter-clear input resets the statistics without touching the capture state.

The buffer memory is a small synchronous RAM model. It keeps the first few words of a handful of page slots, and a slot is picked by the low bits of the page number.

Top module: `emc_monitor_buffer`

## Requirements
- R1: After reset, buf_empty is 1, buf_full is 0, unread_cnt is 0, pg_num is 0, evt_total and word_total are 0, and evt_words is 0 while run_mode is 1.
- R2: An event that begins while the store is not exhausted goes into the page equal to its capture index (0 for the first event after reset). Word k of the event reads back on rd_data at rd_addr = k, one clock after rd_addr is presented. Offsets of 64 or more read as 0. unread_cnt rises by one on the clock that takes the event's last word.
- R3: evt_words gives the latched word count of the event in the slot of pg_num. While run_mode is 1 and no event is unread, it reads 0.
- R4: With run_mode 1, a page command (pg_wr) whose pg_wdata bit 0 is 0 increments pg_num and decrements unread_cnt when unread_cnt is non-zero.
- R5: In run mode, a page command with bit 0 set, or one issued while unread_cnt is 0, leaves pg_num and unread_cnt unchanged.
- R6: With run_mode 0, a page command loads pg_num from pg_wdata and leaves unread_cnt unchanged.
- R7: Only the first 4096 events after reset are stored. buf_full rises on the clock of the 4096th start-of-event and stays high. That event is still stored whole and counted as unread. Later events change neither unread_cnt nor the memory.
- R8: evt_total counts every end-of-event word and word_total counts every valid word, including after buf_full is set.
- R9: cnt_clr zeroes evt_total and word_total and leaves pg_num, unread_cnt and buf_full unchanged.
- R10: buf_empty is 1 exactly when unread_cnt is 0.
- R11: An advance issued on the same clock as a stored event's last word leaves unread_cnt unchanged and still moves pg_num on by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Clears the event and word statistics |
| in_valid | input | 1 | Stream word valid |
| in_sof | input | 1 | Word is the first of an event |
| in_eof | input | 1 | Word is the last of an event |
| in_data | input | 32 | Stream word |
| run_mode | input | 1 | 1: page commands advance; 0: page commands load |
| pg_wr | input | 1 | Page command strobe |
| pg_wdata | input | 13 | Page command value |
| pg_num | output | 13 | Current read page |
| rd_addr | input | 14 | Word offset in the read page |
| rd_data | output | 32 | Word read from the window, one clock later |
| buf_full | output | 1 | Capture limit reached |
| buf_empty | output | 1 | No unread events |
| unread_cnt | output | 12 | Number of unread captured events (saturating) |
| evt_words | output | 14 | Word count of the event in the read page |
| evt_total | output | 32 | Events seen since the last clear |
| word_total | output | 32 | Words seen since the last clear |

## Verification
The properties assume a well-formed stream: every event opens with in_sof, closes with in_eof, and never nests. They also assume the page command is a single-cycle strobe. The stimulus builds every event from a single sender that raises start on the first word and end on the last. It holds the page number steady while it reads through the window, and it drives page commands only as single-cycle pulses. One advance is deliberately placed on the clock of an event's last word, because that is where the unread counter sees an increment and a decrement together.

// File: rtl/emc_pkg.sv
package emc_pkg;
   localparam int EMC_DATA_W = 32;
   localparam int EMC_PAGE_BYTES = 65536;

   typedef enum logic [1:0] {
      PG_NONE,
      PG_ADV,
      PG_LOAD,
      PG_IGN
   } pg_cmd_e;
endpackage

// File: rtl/emc_ram.sv
module emc_ram #(
   parameter int DATA_W = 32,
   parameter int AW     = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   input  logic              rzero,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= rzero ? '0 : mem[raddr];
   end
endmodule

// File: rtl/emc_capture.sv
module emc_capture #(
   parameter int CAP_EVENTS = 4096,
   parameter int CAP_W      = 13,
   parameter int SLOT_W     = 3,
   parameter int SIZE_W     = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   output logic              wr_en,
   output logic [SLOT_W-1:0] wr_slot,
   output logic [SIZE_W-1:0] wr_off,
   output logic              done,
   output logic [SIZE_W-1:0] done_size,
   output logic              full
);
   localparam logic [SIZE_W-1:0] OFF_MAX = '1;
   localparam logic [CAP_W-1:0]  LIMIT   = CAP_W'(CAP_EVENTS);

   logic [CAP_W-1:0]  cap_cnt;
   logic              storing;
   logic [SLOT_W-1:0] cur_slot;
   logic [SIZE_W-1:0] off_q;
   logic              start;
   logic [SIZE_W-1:0] off_next;

   assign full     = (cap_cnt == LIMIT);
   assign start    = in_valid && in_sof && !full;
   assign wr_en    = in_valid && (in_sof ? start : storing);
   assign wr_slot  = in_sof ? cap_cnt[SLOT_W-1:0] : cur_slot;
   assign wr_off   = in_sof ? '0 : off_q;
   assign off_next = (wr_off == OFF_MAX) ? OFF_MAX : wr_off + SIZE_W'(1);
   assign done     = wr_en && in_eof;
   assign done_size = off_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_cnt  <= '0;
         storing  <= 1'b0;
         cur_slot <= '0;
         off_q    <= '0;
      end else begin
         if (start) begin
            cap_cnt  <= cap_cnt + CAP_W'(1);
            cur_slot <= wr_slot;
         end
         if (wr_en) begin
            off_q   <= off_next;
            storing <= !in_eof;
         end else if (in_valid && in_sof) begin
            storing <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/emc_reader.sv
module emc_reader
   import emc_pkg::*;
#(
   parameter int PAGE_W   = 13,
   parameter int SLOT_W   = 3,
   parameter int SIZE_W   = 14,
   parameter int CAP_W    = 13,
   parameter int UNREAD_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [SLOT_W-1:0]   done_slot,
   input  logic [SIZE_W-1:0]   done_size,
   input  logic                run_mode,
   input  logic                pg_wr,
   input  logic [PAGE_W-1:0]   pg_wdata,
   output logic [PAGE_W-1:0]   pg_num,
   output logic [UNREAD_W-1:0] unread_cnt,
   output logic                empty,
   output logic [SIZE_W-1:0]   evt_words
);
   localparam int NSLOT = 1 << SLOT_W;

   logic [CAP_W-1:0]  unread_q;
   logic [SIZE_W-1:0] size_q [NSLOT];
   pg_cmd_e           cmd;

   always_comb begin
      if (!pg_wr)                                   cmd = PG_NONE;
      else if (!run_mode)                           cmd = PG_LOAD;
      else if (!pg_wdata[0] && unread_q != '0)      cmd = PG_ADV;
      else                                          cmd = PG_IGN;
   end

   assign empty     = (unread_q == '0);
   assign evt_words = (run_mode && empty) ? '0 : size_q[pg_num[SLOT_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_num   <= '0;
         unread_q <= '0;
         for (int s = 0; s < NSLOT; s++) size_q[s] <= '0;
      end else begin
         if (cmd == PG_ADV)       pg_num <= pg_num + PAGE_W'(1);
         else if (cmd == PG_LOAD) pg_num <= pg_wdata;
         unread_q <= unread_q + CAP_W'(done) - CAP_W'(cmd == PG_ADV);
         if (done) size_q[done_slot] <= done_size;
      end
   end

   generate
      if (UNREAD_W >= CAP_W) begin : g_wide
         assign unread_cnt = UNREAD_W'(unread_q);
      end else begin : g_sat
         localparam logic [CAP_W-1:0] SAT = CAP_W'((1 << UNREAD_W) - 1);
         assign unread_cnt = (unread_q > SAT) ? '1 : unread_q[UNREAD_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/emc_stats.sv
module emc_stats #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_valid,
   input  logic             in_eof,
   output logic [CNT_W-1:0] evt_total,
   output logic [CNT_W-1:0] word_total
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_total  <= '0;
         word_total <= '0;
      end else if (clr) begin
         evt_total  <= '0;
         word_total <= '0;
      end else if (in_valid) begin
         word_total <= word_total + CNT_W'(1);
         if (in_eof) evt_total <= evt_total + CNT_W'(1);
      end
   end
endmodule

// File: rtl/emc_monitor_buffer.sv
module emc_monitor_buffer
   import emc_pkg::*;
#(
   parameter int DATA_W     = EMC_DATA_W,
   parameter int CNT_W      = 32,
   parameter int CAP_EVENTS = 4096,
   parameter int PAGE_W     = 13,
   parameter int PAGE_BYTES = EMC_PAGE_BYTES,
   parameter int UNREAD_W   = 12,
   parameter int MEM_SLOT_W = 3,
   parameter int MEM_WORD_W = 6,
   localparam int SIZE_W    = $clog2(PAGE_BYTES / (DATA_W / 8)),
   localparam int CAP_W     = $clog2(CAP_EVENTS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cnt_clr,
   input  logic                in_valid,
   input  logic                in_sof,
   input  logic                in_eof,
   input  logic [DATA_W-1:0]   in_data,
   input  logic                run_mode,
   input  logic                pg_wr,
   input  logic [PAGE_W-1:0]   pg_wdata,
   output logic [PAGE_W-1:0]   pg_num,
   input  logic [SIZE_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic                buf_full,
   output logic                buf_empty,
   output logic [UNREAD_W-1:0] unread_cnt,
   output logic [SIZE_W-1:0]   evt_words,
   output logic [CNT_W-1:0]    evt_total,
   output logic [CNT_W-1:0]    word_total
);
   localparam int MEM_AW = MEM_SLOT_W + MEM_WORD_W;

   generate
      if (CAP_EVENTS < 1 || CAP_EVENTS >= (1 << PAGE_W)) begin : g_bad_cap
         $error("CAP_EVENTS must fit the page number");
      end
      if (MEM_SLOT_W > PAGE_W || MEM_WORD_W >= SIZE_W) begin : g_bad_mem
         $error("memory model exceeds page geometry");
      end
      if (MEM_AW > 12) begin : g_bad_depth
         $error("memory model too deep");
      end
   endgenerate

   logic                  wr_en;
   logic [MEM_SLOT_W-1:0] wr_slot;
   logic [SIZE_W-1:0]     wr_off;
   logic                  done;
   logic [SIZE_W-1:0]     done_size;
   logic                  wr_in_win;
   logic                  rd_out_win;

   emc_capture #(
      .CAP_EVENTS(CAP_EVENTS), .CAP_W(CAP_W), .SLOT_W(MEM_SLOT_W), .SIZE_W(SIZE_W)
   ) i_capture (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_off(wr_off),
      .done(done), .done_size(done_size), .full(buf_full)
   );

   assign wr_in_win  = (wr_off >> MEM_WORD_W) == '0;
   assign rd_out_win = (rd_addr >> MEM_WORD_W) != '0;

   emc_ram #(.DATA_W(DATA_W), .AW(MEM_AW)) i_ram (
      .clk(clk),
      .we(wr_en && wr_in_win),
      .waddr({wr_slot, wr_off[MEM_WORD_W-1:0]}),
      .wdata(in_data),
      .raddr({pg_num[MEM_SLOT_W-1:0], rd_addr[MEM_WORD_W-1:0]}),
      .rzero(rd_out_win),
      .rdata(rd_data)
   );

   emc_reader #(
      .PAGE_W(PAGE_W), .SLOT_W(MEM_SLOT_W), .SIZE_W(SIZE_W),
      .CAP_W(CAP_W), .UNREAD_W(UNREAD_W)
   ) i_reader (
      .clk(clk), .rst_n(rst_n), .done(done), .done_slot(wr_slot), .done_size(done_size),
      .run_mode(run_mode), .pg_wr(pg_wr), .pg_wdata(pg_wdata),
      .pg_num(pg_num), .unread_cnt(unread_cnt), .empty(buf_empty), .evt_words(evt_words)
   );

   emc_stats #(.CNT_W(CNT_W)) i_stats (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .in_valid(in_valid), .in_eof(in_eof),
      .evt_total(evt_total), .word_total(word_total)
   );
endmodule

// File: rtl/emc_monitor_buffer_chk.sv
module emc_monitor_buffer_chk #(
   parameter int PAGE_W   = 13,
   parameter int UNREAD_W = 12,
   parameter int CNT_W    = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cnt_clr,
   input logic                in_valid,
   input logic                in_eof,
   input logic                run_mode,
   input logic                pg_wr,
   input logic [PAGE_W-1:0]   pg_wdata,
   input logic [PAGE_W-1:0]   pg_num,
   input logic                buf_full,
   input logic                buf_empty,
   input logic [UNREAD_W-1:0] unread_cnt,
   input logic [CNT_W-1:0]    evt_total,
   input logic [CNT_W-1:0]    word_total
);
   // R7
   full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |=> buf_full);

   // R5
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_wr |=> $stable(pg_num));

   // R4
   page_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_wr && run_mode && !pg_wdata[0] && !buf_empty) |=> pg_num == $past(pg_num) + PAGE_W'(1));

   // R6
   page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_wr && !run_mode) |=> pg_num == $past(pg_wdata));

   // R2
   unread_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_eof) |=> unread_cnt <= $past(unread_cnt));

   // R9
   stats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (evt_total == '0 && word_total == '0));
endmodule

bind emc_monitor_buffer emc_monitor_buffer_chk #(
   .PAGE_W(PAGE_W), .UNREAD_W(UNREAD_W), .CNT_W(CNT_W)
) i_emc_chk (
   .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .in_valid(in_valid), .in_eof(in_eof),
   .run_mode(run_mode), .pg_wr(pg_wr), .pg_wdata(pg_wdata), .pg_num(pg_num),
   .buf_full(buf_full), .buf_empty(buf_empty), .unread_cnt(unread_cnt),
   .evt_total(evt_total), .word_total(word_total)
);

// File: tb/test_emc_monitor_buffer.sv
module test_emc_monitor_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_clr = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [31:0] in_data = '0;
   logic        run_mode = 1'b1;
   logic        pg_wr = 1'b0;
   logic [12:0] pg_wdata = '0;
   logic [12:0] pg_num;
   logic [13:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        buf_full, buf_empty;
   logic [11:0] unread_cnt;
   logic [13:0] evt_words;
   logic [31:0] evt_total, word_total;

   int n_vec = 0;
   int n_bad = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   emc_monitor_buffer i_emc_monitor_buffer (
      .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data), .run_mode(run_mode), .pg_wr(pg_wr),
      .pg_wdata(pg_wdata), .pg_num(pg_num), .rd_addr(rd_addr), .rd_data(rd_data),
      .buf_full(buf_full), .buf_empty(buf_empty), .unread_cnt(unread_cnt),
      .evt_words(evt_words), .evt_total(evt_total), .word_total(word_total)
   );

   function automatic logic [31:0] word_of(int idx, int w);
      return {idx[15:0], w[15:0]} ^ 32'h5A00_00C3;
   endfunction

   task automatic check(string req, string what, longint act, longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: compares the read word one clock after its address
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         automatic logic [31:0] e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         n_vec++;
         if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s window data: actual %h expected %h", t, rd_data, e);
         end
      end
   end

   task automatic send_ev(int idx, int len);
      for (int w = 0; w < len; w++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof = (w == 0);
         in_eof = (w == len - 1);
         in_data = word_of(idx, w);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
   endtask

   task automatic read_page(string req, int idx, int len);
      for (int w = 0; w < len; w++) begin
         @(negedge clk); #1;
         rd_addr = 14'(w);
         exp_q.push_back(word_of(idx, w));
         tag_q.push_back(req);
      end
      @(negedge clk); #1;
   endtask

   task automatic pg_cmd(logic run, logic [12:0] d);
      @(negedge clk);
      run_mode = run; pg_wr = 1'b1; pg_wdata = d;
      @(negedge clk);
      pg_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "empty", buf_empty, 1);
      check("R1", "full", buf_full, 0);
      check("R1", "unread", unread_cnt, 0);
      check("R1", "page", pg_num, 0);
      check("R1", "evt_words", evt_words, 0);
      check("R1", "totals", evt_total + word_total, 0);

      // R2 capture of three events of different shapes
      send_ev(0, 3);
      check("R2", "unread after ev0", unread_cnt, 1);
      send_ev(1, 1);
      send_ev(2, 5);
      check("R2", "unread", unread_cnt, 3);
      check("R10", "empty with unread", buf_empty, 0);
      check("R3", "size page0", evt_words, 3);
      read_page("R2", 0, 3);
      @(negedge clk); #1; rd_addr = 14'd64;
      @(negedge clk);
      check("R2", "beyond window", rd_data, 0);

      // R4 advance
      pg_cmd(1'b1, 13'h0);
      check("R4", "page", pg_num, 1);
      check("R4", "unread", unread_cnt, 2);
      check("R4", "size page1", evt_words, 1);
      read_page("R4", 1, 1);

      // R5 bit 0 set is ignored
      pg_cmd(1'b1, 13'h1);
      check("R5", "page bit0", pg_num, 1);
      check("R5", "unread bit0", unread_cnt, 2);

      // R6 direct load
      pg_cmd(1'b0, 13'd2);
      check("R6", "page load", pg_num, 2);
      check("R6", "unread load", unread_cnt, 2);
      check("R6", "size page2", evt_words, 5);
      read_page("R6", 2, 5);
      pg_cmd(1'b0, 13'd1);
      pg_cmd(1'b1, 13'h0);
      pg_cmd(1'b1, 13'h0);
      check("R4", "page after two", pg_num, 3);
      check("R10", "empty", buf_empty, 1);
      check("R3", "size when empty", evt_words, 0);
      pg_cmd(1'b1, 13'h0);
      check("R5", "page at zero", pg_num, 3);
      check("R5", "unread at zero", unread_cnt, 0);

      // R11 advance coinciding with a stored end-of-event
      send_ev(3, 2);
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = word_of(4, 0);
      @(negedge clk);
      in_sof = 1'b0; in_eof = 1'b1; in_data = word_of(4, 1);
      pg_wr = 1'b1; pg_wdata = 13'h0;
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b0; pg_wr = 1'b0;
      check("R11", "unread", unread_cnt, 1);
      check("R11", "page", pg_num, 4);
      check("R3", "size page4", evt_words, 2);
      read_page("R11", 4, 2);

      // R8 totals, R9 clear
      check("R8", "evt_total", evt_total, 5);
      check("R8", "word_total", word_total, 13);
      @(negedge clk); cnt_clr = 1'b1;
      @(negedge clk); cnt_clr = 1'b0;
      check("R9", "totals cleared", evt_total + word_total, 0);
      check("R9", "unread kept", unread_cnt, 1);
      check("R9", "page kept", pg_num, 4);

      // R7 limit
      for (int i = 5; i < 4095; i++) send_ev(i, 1);
      check("R7", "full before limit", buf_full, 0);
      check("R7", "unread before limit", unread_cnt, 4091);
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = word_of(4095, 0);
      @(negedge clk);
      check("R7", "full at last start", buf_full, 1);
      check("R7", "unread mid event", unread_cnt, 4091);
      in_sof = 1'b0; in_eof = 1'b1; in_data = word_of(4095, 1);
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b0;
      check("R7", "last event stored", unread_cnt, 4092);
      send_ev(4096, 3);
      check("R7", "after limit unread", unread_cnt, 4092);
      check("R7", "still full", buf_full, 1);
      check("R8", "evt_total after full", evt_total, 4092);
      check("R8", "word_total after full", word_total, 4095);
      pg_cmd(1'b0, 13'd4095);
      check("R7", "size last stored", evt_words, 2);
      read_page("R7", 4095, 2);
      pg_cmd(1'b0, 13'd4096);
      check("R7", "slot not rewritten size", evt_words, 1);
      read_page("R7", 4088, 1);

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule